// File: doc/BRIEF.md
# Random Boolean Network Engine

The engine holds a network of binary nodes that all advance together on each enabled clock step. Every node picks a fixed number of input bits out of the whole state vector, through a per-node table of source indices. It then uses that input pattern to look up its next value in a per-node rule table. Any node may feed any other node, and a node may also feed itself. Each node therefore has its own wiring and its own rule, with no fixed neighbourhood and no shared rule.

Software first writes the source indices and rule tables through a single write port while the engine is stopped. A seed load then places a starting configuration in the state register. Raising the run enable advances the network by one step per clock. The full state vector and a count of steps taken since the last seed load are visible at all times.

Top module: `rbn_engine`

## Requirements
- R1: After reset the state vector is all zero and the step count is zero.
- R2: A cycle with `seedLoad` high makes the state equal to `seed` and the step count zero at the next edge. This holds even when `runEn` is also high, and no step happens in that cycle.
- R3: On a step, node n takes bit p of its rule table as its next value. The index p is formed from the states of its selected sources, with slot 0 as bit 0 of p and slot 1 as bit 1.
- R4: All nodes update at once from the states of the previous step. A ring in which each node copies its upper neighbour rotates the vector by one place per step.
- R5: A source index may name any node, including the node itself.
- R6: The step count rises by one for each step taken while `runEn` is high and wraps to zero after 2^STEP_W steps.
- R7: While `runEn` and `seedLoad` are both low, the state and the step count hold.
- R8: A write with `cfgWe` high and `runEn` low stores data as follows. With `cfgSel`=0, `cfgData[IDX_W-1:0]` becomes the source of slot `cfgSlot` of node `cfgNode`. With `cfgSel`=1, `cfgData[LUT_SIZE-1:0]` becomes the rule table of node `cfgNode`. The new value governs every later step.
- R9: Configuration writes made while `runEn` is high are ignored.
- R10: After reset every source index is node 0 and every rule table is zero, so one step clears all nodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Step enable; also blocks configuration writes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = source index, 1 = rule table |
| cfgNode | input | IDX_W | Target node |
| cfgSlot | input | SLOT_W | Target input slot (source writes only) |
| cfgData | input | CFG_W | Written value |
| seedLoad | input | 1 | Load seed and clear step count |
| seed | input | NODES | Initial state vector |
| state | output | NODES | Current node states |
| stepCount | output | STEP_W | Steps taken since last seed load |

## Verification
A fixed irregular wiring with asymmetric rule tables and one self-looped node runs from several seeds: all-zero, all-one, alternating, single-bit and mixed. These show whether slot order, self-feedback and rule indexing are right on every step. A ring configuration that copies neighbours shows whether the update is truly simultaneous, because a sequential update would smear a single one across the ring instead of rotating it. Writes attempted during a run, a seed load that coincides with a step, and a full counter wrap separate the priority, lockout and counting rules.

// File: rtl/rbn_pkg.sv
package rbn_pkg;
  // Strobes from the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic srcWr;     // store one source index
    logic lutWr;     // store one rule table
    logic loadSeed;  // copy seed into the state
    logic step;      // advance every node once
  } rbnStrobe_t;
endpackage

// File: rtl/rbn_ctrl.sv
module rbn_ctrl #(
  parameter int STEP_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                cfgWe,
  input  logic                cfgSel,
  input  logic                seedLoad,
  output rbn_pkg::rbnStrobe_t strobe,
  output logic [STEP_W-1:0]   stepCount
);
  import rbn_pkg::*;

  logic cfgOpen;

  // Configuration is locked out while the network runs.
  assign cfgOpen         = cfgWe && !runEn;
  assign strobe.srcWr    = cfgOpen && !cfgSel;
  assign strobe.lutWr    = cfgOpen && cfgSel;
  assign strobe.loadSeed = seedLoad;
  // A seed load takes precedence over a step in the same cycle.
  assign strobe.step     = runEn && !seedLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCount <= '0;
    end else if (strobe.loadSeed) begin
      stepCount <= '0;
    end else if (strobe.step) begin
      stepCount <= stepCount + 1'b1;
    end
  end

  // R6
  count_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !seedLoad) |=> stepCount == STEP_W'($past(stepCount) + 1'b1));

  // R2
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> stepCount == '0);

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !seedLoad) |=> $stable(stepCount));

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> !(strobe.srcWr || strobe.lutWr));
endmodule

// File: rtl/rbn_datapath.sv
module rbn_datapath #(
  parameter int NODES    = 16,
  parameter int FANIN    = 2,
  parameter int IDX_W    = 4,
  parameter int SLOT_W   = 1,
  parameter int LUT_SIZE = 4,
  parameter int CFG_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  rbn_pkg::rbnStrobe_t strobe,
  input  logic [IDX_W-1:0]    cfgNode,
  input  logic [SLOT_W-1:0]   cfgSlot,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic [NODES-1:0]    seed,
  output logic [NODES-1:0]    state
);
  import rbn_pkg::*;

  localparam bit FULL_RANGE = ((1 << IDX_W) == NODES);

  logic [NODES-1:0][FANIN-1:0][IDX_W-1:0] srcMem;
  logic [NODES-1:0][LUT_SIZE-1:0]         lutMem;
  logic [NODES-1:0]                       nextState;
  logic                                   nodeOk;
  logic                                   slotOk;

  assign nodeOk = int'(cfgNode) < NODES;
  assign slotOk = int'(cfgSlot) < FANIN;

  // Wiring and rule storage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcMem <= '0;
      lutMem <= '0;
    end else begin
      if (strobe.srcWr && nodeOk && slotOk) begin
        srcMem[cfgNode][cfgSlot] <= cfgData[IDX_W-1:0];
      end
      if (strobe.lutWr && nodeOk) begin
        lutMem[cfgNode] <= cfgData[LUT_SIZE-1:0];
      end
    end
  end

  // Per-node input gather and rule lookup, all from the current state.
  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [FANIN-1:0] pattern;
    for (genvar s = 0; s < FANIN; s++) begin : g_slot
      if (FULL_RANGE) begin : g_direct
        assign pattern[s] = state[srcMem[n][s]];
      end else begin : g_guard
        // Indices past the last node read as a constant zero.
        assign pattern[s] = (int'(srcMem[n][s]) < NODES) ?
                            state[srcMem[n][s]] : 1'b0;
      end
    end
    assign nextState[n] = lutMem[n][pattern];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= '0;
    end else if (strobe.loadSeed) begin
      state <= seed;
    end else if (strobe.step) begin
      state <= nextState;
    end
  end

  // R2
  seed_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSeed |=> state == $past(seed));

  // R7
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.step || strobe.loadSeed) |=> $stable(state));

  // R9
  lut_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lutWr |=> $stable(lutMem));

  // R9
  src_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.srcWr |=> $stable(srcMem));
endmodule

// File: rtl/rbn_engine.sv
module rbn_engine #(
  parameter int NODES    = 16,
  parameter int FANIN    = 2,
  parameter int STEP_W   = 16,
  parameter int IDX_W    = (NODES > 1) ? $clog2(NODES) : 1,
  parameter int SLOT_W   = (FANIN > 1) ? $clog2(FANIN) : 1,
  parameter int LUT_SIZE = 1 << FANIN,
  parameter int CFG_W    = (IDX_W > LUT_SIZE) ? IDX_W : LUT_SIZE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgNode,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              seedLoad,
  input  logic [NODES-1:0]  seed,
  output logic [NODES-1:0]  state,
  output logic [STEP_W-1:0] stepCount
);
  import rbn_pkg::*;

  rbnStrobe_t strobe;

  rbn_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .seedLoad  (seedLoad),
    .strobe    (strobe),
    .stepCount (stepCount)
  );

  rbn_datapath #(
    .NODES    (NODES),
    .FANIN    (FANIN),
    .IDX_W    (IDX_W),
    .SLOT_W   (SLOT_W),
    .LUT_SIZE (LUT_SIZE),
    .CFG_W    (CFG_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgNode (cfgNode),
    .cfgSlot (cfgSlot),
    .cfgData (cfgData),
    .seed    (seed),
    .state   (state)
  );
endmodule

// File: tb/rbn_engine_bench.sv
`timescale 1ns/1ps
module rbn_engine_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [3:0]  cfgNode = '0;
  logic [0:0]  cfgSlot = '0;
  logic [3:0]  cfgData = '0;
  logic        seedLoad = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] state;
  logic [15:0] stepCount;

  int checks = 0;
  int errors = 0;

  // Bench-side model of the wiring, built from R3/R8.
  int         bSrc [N][2];
  logic [3:0] bLut [N];
  logic [15:0] mState;

  always #10 clk = ~clk;  // 50 MHz

  rbn_engine u_rbn_engine (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgNode(cfgNode), .cfgSlot(cfgSlot), .cfgData(cfgData),
    .seedLoad(seedLoad), .seed(seed), .state(state), .stepCount(stepCount)
  );

  // Stimulus vectors: seed and number of steps to run from it.
  localparam logic [15:0] VSEED  [0:5] = '{16'h0000, 16'hFFFF, 16'hAAAA,
                                           16'h0001, 16'hC35A, 16'h8421};
  localparam int          VSTEPS [0:5] = '{3, 5, 7, 4, 9, 6};

  function automatic logic [15:0] modelStep(logic [15:0] s);
    logic [15:0] r;
    for (int n = 0; n < N; n++) begin
      logic [1:0] p;
      p = {s[bSrc[n][1]], s[bSrc[n][0]]};
      r[n] = bLut[n][p];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic sel, int node, int slot, logic [3:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgNode = 4'(node);
    cfgSlot = 1'(slot); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setNode(int n, int s0, int s1, logic [3:0] lut);
    cfgWrite(1'b0, n, 0, 4'(s0));
    cfgWrite(1'b0, n, 1, 4'(s1));
    cfgWrite(1'b1, n, 0, lut);
    bSrc[n][0] = s0; bSrc[n][1] = s1; bLut[n] = lut;
  endtask

  task automatic loadSeed(logic [15:0] v);
    seedLoad = 1'b1; seed = v;
    @(negedge clk);
    seedLoad = 1'b0;
    mState = v;
    check("R2 seed", 32'(state), 32'(v));
    check("R2 count clear", 32'(stepCount), 0);
  endtask

  task automatic runSteps(int k, string req);
    runEn = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      mState = modelStep(mState);
      check(req, 32'(state), 32'(mState));
    end
    runEn = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin
      bSrc[n][0] = 0; bSrc[n][1] = 0; bLut[n] = 4'h0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 state", 32'(state), 0);
    check("R1 count", 32'(stepCount), 0);

    // R10 cleared tables drive every node to zero
    loadSeed(16'hFFFF);
    runEn = 1'b1; @(negedge clk); runEn = 1'b0;
    check("R10 cleared", 32'(state), 0);
    check("R6 one step", 32'(stepCount), 1);

    // R8 irregular wiring, asymmetric rules; node 5 feeds itself (R5)
    for (int n = 0; n < N; n++) begin
      int s0, s1;
      s0 = (n == 5) ? 5 : (n * 7 + 3) % N;
      s1 = (n * 5 + 11) % N;
      setNode(n, s0, s1, 4'((n * 7 + 2) % 16));
    end
    setNode(5, 5, 9, 4'b0110);

    // Vector table walk: R3 indexing with slot 0 as LSB, R5 self-loop, R6 count
    for (int v = 0; v < 6; v++) begin
      loadSeed(VSEED[v]);
      runSteps(VSTEPS[v], "R3 step");
      check("R6 count", 32'(stepCount), 32'(VSTEPS[v]));
    end

    // R5 self-loop isolated: node 5 rule 0110 is XOR of itself and node 9
    loadSeed(16'h0020);
    runSteps(1, "R5 self");

    // R7 hold while idle
    begin
      logic [15:0] held;
      logic [15:0] heldCnt;
      held = state; heldCnt = stepCount;
      repeat (5) @(negedge clk);
      check("R7 state hold", 32'(state), 32'(held));
      check("R7 count hold", 32'(stepCount), 32'(heldCnt));
    end

    // R9 writes while running are ignored
    loadSeed(16'h5A3C);
    runEn = 1'b1;
    cfgWe = 1'b1; cfgSel = 1'b1; cfgNode = 4'd0; cfgData = ~bLut[0];
    repeat (3) begin
      @(negedge clk);
      mState = modelStep(mState);
      check("R9 ignored write", 32'(state), 32'(mState));
    end
    cfgSel = 1'b0; cfgData = 4'(bSrc[1][0] ^ 4'hF); cfgNode = 4'd1;
    @(negedge clk);
    mState = modelStep(mState);
    cfgWe = 1'b0; runEn = 1'b0;
    check("R9 ignored src", 32'(state), 32'(mState));
    runSteps(4, "R9 table kept");

    // R8 reconfigure a rule while stopped, takes effect next step
    setNode(2, bSrc[2][0], bSrc[2][1], ~bLut[2]);
    loadSeed(16'h3C3C);
    runSteps(3, "R8 new rule");

    // R2 seed load wins over a coincident step
    runEn = 1'b1; seedLoad = 1'b1; seed = 16'hBEEF;
    @(negedge clk);
    seedLoad = 1'b0; runEn = 1'b0;
    check("R2 priority state", 32'(state), 32'h0000BEEF);
    check("R2 priority count", 32'(stepCount), 0);

    // R4 copy ring: node n takes node n+1, so the vector rotates right
    for (int n = 0; n < N; n++) setNode(n, (n + 1) % N, (n + 1) % N, 4'b1010);
    loadSeed(16'h0001);
    runEn = 1'b1; @(negedge clk); runEn = 1'b0;
    check("R4 rotate", 32'(state), 32'h00008000);
    runEn = 1'b1; @(negedge clk); runEn = 1'b0;
    check("R4 rotate twice", 32'(state), 32'h00004000);

    // R6 wrap after 2^16 steps; ring returns to its seed
    loadSeed(16'h0013);
    runEn = 1'b1;
    repeat (65535) @(negedge clk);
    check("R6 count max", 32'(stepCount), 32'h0000FFFF);
    @(negedge clk);
    runEn = 1'b0;
    check("R6 wrap", 32'(stepCount), 0);
    check("R4 ring period", 32'(state), 32'h00000013);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule